// File: doc/BRIEF.md
# Radix-2 Decimation-in-Frequency Pipeline Stage

This block is one stage of a single-path pipelined FFT built from radix-2 decimation-in-frequency butterflies. It is sized for a span of `N` points. It accepts one complex sample on every clock on which `ce` is high. It holds the first half of each span in a local memory. When the second half arrives, each fresh sample is combined with the sample that came `N/2` positions earlier. The butterfly produces the sum of the two and the difference of the two, the difference rotated by a twiddle factor. The twiddle factors are computed from the span size when the design is elaborated.

The sum leaves the stage at once. The rotated difference is parked in a second memory and leaves during the next `N/2` enabled cycles, while the butterfly is busy with the first half of the next span. The outgoing stream therefore has no gaps. A marker pulse travels through the butterfly pipeline next to the first pair of a span. When it comes out, it starts the output sequencing, so the output ordering stays correct for any multiplier latency.

`ce` acts as a shared valid-and-advance strobe. There is no ready signal and no back-pressure. Every internal register, including the output register, moves only on enabled cycles. The consumer must take `out_sample` after each enabled edge. Several stages can be chained, each halving `N`. Reset is synchronous and active high. `N` must be a power of two, at least 4, and `TW` must lie between 3 and 30.

Top module: `fftstg_dif_stage`

## Requirements
- R1: While `rst` is high, and after it until the first enabled edge, `out_sync` is 0 and `out_sample` is 0.
- R2: Samples pack the real part in the upper half (`[2W-1:W]`) and the imaginary part in the lower half, both in two's complement. For span inputs x[0..N-1] and 0 <= k < N/2, output k of the span equals x[k] + x[k+N/2], computed at width DW+1 so that it never overflows.
- R3: Output N/2+k of the span equals ((x[k] - x[k+N/2]) * W_k) shifted arithmetically right by TW-2 and wrapped to DW+1 bits per part. W_k is rounded to the nearest integer of 2^(TW-2)·(cos(2πk/N) − j·sin(2πk/N)).
- R4: `out_sync` is high after exactly the enabled edge that is N/2+MPY_LAT+1 enabled edges past the edge that accepted a span's first sample. At that edge it comes together with output 0 of the span, and it is low after every other enabled edge.
- R5: On cycles with `ce` low, no state moves: `out_sample` and `out_sync` hold their values, and a gap in `ce` does not change any later result.
- R6: Once sequencing has started, spans follow back to back without further `in_sync`. The index wraps from N-1 to 0, and every span is produced in full and in order.
- R7: Samples accepted before the first `in_sync` are discarded and produce no output sync. A sample accepted with `in_sync` high always becomes index 0 of a new span, even in the middle of a span.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Enable: accepts a sample and advances the pipeline |
| in_sample | input | 2*DW | Complex input sample, real part in the upper half |
| in_sync | input | 1 | Marks the sample that is index 0 of a span |
| out_sample | output | 2*(DW+1) | Complex output sample, real part in the upper half |
| out_sync | output | 1 | Marks output 0 of a span |

## Verification
The bench builds the stage with N=8, DW=10, TW=12 and MPY_LAT=2. With these values there are dozens of complete spans in a short run, and the multiplier latency differs from N/2, so a mix-up between the two shows as a misplaced sync. With a 10-bit input, the 45-degree twiddle of 724 applied to a maximal difference makes the wrap-around of R3 happen. Random enable gaps and an in_sync that restarts a span in its first half exercise the hold and restart rules.

// File: rtl/fftstg_pkg.sv
package fftstg_pkg;

  localparam real PI_C = 3.14159265358979323846;

  // Twiddle coordinate for position k of a span, scaled and rounded to nearest.
  function automatic int twiddle_coord(int k, int span, int scale, bit imag_part);
    real ang;
    real v;
    ang = 2.0 * PI_C * $itor(k) / $itor(span);
    if (imag_part) v = 0.0 - $sin(ang);
    else           v = $cos(ang);
    return $rtoi($floor(v * $itor(scale) + 0.5));
  endfunction

endpackage

// File: rtl/fftstg_twiddle_rom.sv
module fftstg_twiddle_rom #(
  parameter int N  = 16,
  parameter int TW = 16,
  parameter int AW = 3
) (
  input  logic [AW-1:0]        addr_i,
  output logic signed [TW-1:0] w_re_o,
  output logic signed [TW-1:0] w_im_o
);
  localparam int H     = N / 2;
  localparam int SCALE = 1 << (TW - 2);

  logic signed [TW-1:0] re_tab [H];
  logic signed [TW-1:0] im_tab [H];

  for (genvar k = 0; k < H; k++) begin : g_ent
    localparam int VRE = fftstg_pkg::twiddle_coord(k, N, SCALE, 1'b0);
    localparam int VIM = fftstg_pkg::twiddle_coord(k, N, SCALE, 1'b1);
    assign re_tab[k] = TW'(VRE);
    assign im_tab[k] = TW'(VIM);
  end

  assign w_re_o = re_tab[addr_i];
  assign w_im_o = im_tab[addr_i];

endmodule

// File: rtl/fftstg_cmul.sv
module fftstg_cmul #(
  parameter int OW  = 13,
  parameter int TW  = 16,
  parameter int LAT = 3,
  parameter int SW  = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ce,
  input  logic signed [OW-1:0] d_re_i,
  input  logic signed [OW-1:0] d_im_i,
  input  logic signed [TW-1:0] w_re_i,
  input  logic signed [TW-1:0] w_im_i,
  input  logic [SW-1:0]        side_i,
  output logic signed [OW-1:0] p_re_o,
  output logic signed [OW-1:0] p_im_o,
  output logic [SW-1:0]        side_o
);
  localparam int PW = OW + TW + 1;
  localparam int SH = TW - 2;
  localparam int EW = 2 * OW + SW;

  logic signed [PW-1:0] dr, di, wr, wi, pr, pi;

  always_comb begin
    dr = PW'(d_re_i);
    di = PW'(d_im_i);
    wr = PW'(w_re_i);
    wi = PW'(w_im_i);
    pr = dr * wr - di * wi;
    pi = dr * wi + di * wr;
  end

  logic [EW-1:0] stg [LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LAT; i++) stg[i] <= '0;
    end else if (ce) begin
      stg[0] <= {OW'(pr >>> SH), OW'(pi >>> SH), side_i};
      for (int i = 1; i < LAT; i++) stg[i] <= stg[i-1];
    end
  end

  assign {p_re_o, p_im_o, side_o} = stg[LAT-1];

  // R5: the product pipeline is frozen while ce is low
  assert_cmul_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(p_re_o) && $stable(p_im_o) && $stable(side_o));

endmodule

// File: rtl/fftstg_bfly.sv
module fftstg_bfly #(
  parameter int DW  = 12,
  parameter int TW  = 16,
  parameter int LAT = 3,
  parameter int OW  = DW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ce,
  input  logic [2*DW-1:0]      a_i,
  input  logic [2*DW-1:0]      b_i,
  input  logic signed [TW-1:0] w_re_i,
  input  logic signed [TW-1:0] w_im_i,
  input  logic                 sync_i,
  output logic [2*OW-1:0]      s0_o,
  output logic [2*OW-1:0]      s1_o,
  output logic                 sync_o
);
  localparam int SW = 2 * OW + 1;

  logic signed [DW-1:0] ar, ai, br, bi;
  assign ar = a_i[2*DW-1:DW];
  assign ai = a_i[DW-1:0];
  assign br = b_i[2*DW-1:DW];
  assign bi = b_i[DW-1:0];

  logic signed [OW-1:0] sum_re, sum_im, dif_re, dif_im;
  logic signed [TW-1:0] wr_q, wi_q;
  logic                 sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_re <= '0; sum_im <= '0;
      dif_re <= '0; dif_im <= '0;
      wr_q   <= '0; wi_q   <= '0;
      sync_q <= 1'b0;
    end else if (ce) begin
      sum_re <= OW'(ar) + OW'(br);
      sum_im <= OW'(ai) + OW'(bi);
      dif_re <= OW'(ar) - OW'(br);
      dif_im <= OW'(ai) - OW'(bi);
      wr_q   <= w_re_i;
      wi_q   <= w_im_i;
      sync_q <= sync_i;
    end
  end

  logic [SW-1:0]        side_out;
  logic signed [OW-1:0] p_re, p_im;

  fftstg_cmul #(.OW(OW), .TW(TW), .LAT(LAT), .SW(SW)) u_mul (
    .clk    (clk),
    .rst    (rst),
    .ce     (ce),
    .d_re_i (dif_re),
    .d_im_i (dif_im),
    .w_re_i (wr_q),
    .w_im_i (wi_q),
    .side_i ({sum_re, sum_im, sync_q}),
    .p_re_o (p_re),
    .p_im_o (p_im),
    .side_o (side_out)
  );

  assign s0_o   = side_out[SW-1:1];
  assign sync_o = side_out[0];
  assign s1_o   = {p_re, p_im};

  // R5: butterfly results hold between enabled edges
  assert_bfly_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(s0_o) && $stable(s1_o) && $stable(sync_o));

endmodule

// File: rtl/fftstg_dif_stage.sv
module fftstg_dif_stage #(
  parameter int N       = 16,
  parameter int DW      = 12,
  parameter int TW      = 16,
  parameter int MPY_LAT = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ce,
  input  logic [2*DW-1:0]       in_sample,
  input  logic                  in_sync,
  output logic [2*(DW+1)-1:0]   out_sample,
  output logic                  out_sync
);
  localparam int H  = N / 2;
  localparam int AW = $clog2(H);
  localparam int CW = AW + 1;
  localparam int OW = DW + 1;

  // ---------------- input side: fill, then pair ----------------
  logic [CW-1:0]   in_cnt;
  logic            in_run;
  logic [CW-1:0]   in_idx;
  logic [2*DW-1:0] hold_mem [H];
  logic [2*DW-1:0] held;

  assign in_idx = in_sync ? '0 : in_cnt;
  assign held   = hold_mem[in_idx[AW-1:0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      in_cnt <= '0;
      in_run <= 1'b0;
    end else if (ce && (in_sync || in_run)) begin
      in_run <= 1'b1;
      in_cnt <= in_idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ce && !in_idx[AW]) hold_mem[in_idx[AW-1:0]] <= in_sample;
  end

  logic pair_sync;
  assign pair_sync = (in_idx == CW'(H));

  logic signed [TW-1:0] w_re, w_im;

  fftstg_twiddle_rom #(.N(N), .TW(TW), .AW(AW)) u_rom (
    .addr_i (in_idx[AW-1:0]),
    .w_re_o (w_re),
    .w_im_o (w_im)
  );

  logic [2*OW-1:0] bf_s0, bf_s1;
  logic            bf_sync;

  fftstg_bfly #(.DW(DW), .TW(TW), .LAT(MPY_LAT), .OW(OW)) u_bfly (
    .clk    (clk),
    .rst    (rst),
    .ce     (ce),
    .a_i    (held),
    .b_i    (in_sample),
    .w_re_i (w_re),
    .w_im_i (w_im),
    .sync_i (pair_sync),
    .s0_o   (bf_s0),
    .s1_o   (bf_s1),
    .sync_o (bf_sync)
  );

  // ---------------- output side: pass, then replay ----------------
  logic [CW-1:0]   out_cnt;
  logic            out_run;
  logic [CW-1:0]   out_idx;
  logic [2*OW-1:0] spill_mem [H];

  assign out_idx = bf_sync ? '0 : out_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_cnt    <= '0;
      out_run    <= 1'b0;
      out_sync   <= 1'b0;
      out_sample <= '0;
    end else if (ce) begin
      if (bf_sync || out_run) begin
        out_run <= 1'b1;
        out_cnt <= out_idx + 1'b1;
      end
      out_sync   <= bf_sync;
      out_sample <= out_idx[AW] ? spill_mem[out_idx[AW-1:0]] : bf_s0;
    end
  end

  always_ff @(posedge clk) begin
    if (ce && !out_idx[AW]) spill_mem[out_idx[AW-1:0]] <= bf_s1;
  end

  // ---------------- checks ----------------
  // Enabled edges since the last butterfly sync, saturating.
  logic [CW-1:0] gap_cnt;
  logic          gap_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt  <= '0;
      gap_seen <= 1'b0;
    end else if (ce) begin
      if (bf_sync) begin
        gap_cnt  <= CW'(1);
        gap_seen <= 1'b1;
      end else if (gap_cnt < CW'(H + 1)) begin
        gap_cnt <= gap_cnt + 1'b1;
      end
    end
  end

  // R7: a restart can never bring two pair markers closer than N/2+1 edges
  assert_sync_gap_R7: assert property (@(posedge clk) disable iff (rst)
    (ce && bf_sync && gap_seen) |-> gap_cnt >= CW'(H + 1));

  // R1: first cycle after reset shows the cleared outputs
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_sync && out_sample == '0));

  // R5: outputs and sequencing state hold while ce is low
  assert_out_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(out_sample) && $stable(out_sync));

  assert_cnt_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(in_cnt) && $stable(out_cnt) && $stable(in_run) && $stable(out_run));

endmodule

// File: tb/fftstg_dif_stage_tb_top.sv
module fftstg_dif_stage_tb_top;
  localparam int N    = 8;
  localparam int DW   = 10;
  localparam int TW   = 12;
  localparam int LAT  = 2;
  localparam int H    = N / 2;
  localparam int OW   = DW + 1;
  localparam int HIST = 1024;
  localparam real PI  = 3.14159265358979323846;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst = 1'b1;
  logic            ce = 1'b0;
  logic            in_sync = 1'b0;
  logic [2*DW-1:0] in_sample = '0;
  logic [2*OW-1:0] out_sample;
  logic            out_sync;

  fftstg_dif_stage #(.N(N), .DW(DW), .TW(TW), .MPY_LAT(LAT)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .ce         (ce),
    .in_sample  (in_sample),
    .in_sync    (in_sync),
    .out_sample (out_sample),
    .out_sync   (out_sync)
  );

  int errs = 0;
  int checks = 0;
  int ecount = 0;
  logic [2*DW-1:0] hist [HIST];
  int    q_edge[$];
  int    q_start[$];
  string q_tag[$];
  bit    m_run = 0;
  int    m_cnt = 0;
  bit    act = 0;
  int    cur_start = 0;
  int    pos = 0;
  string cur_tag = "";
  bit    prev_ce = 0;
  bit    span_tag_restart = 0;
  bit    span_tag_nosync = 0;
  logic [2*OW-1:0] last_out = '0;
  logic            last_sync = 1'b0;
  bit    done = 0;

  task automatic check(bit ok, string req, longint got, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: got %0h expected %0h (edge %0d)", req, got, exp, ecount);
    end
  endtask

  function automatic longint twid(int k, bit im);
    real ang, v;
    ang = 2.0 * PI * $itor(k) / $itor(N);
    v = im ? (0.0 - $sin(ang)) : $cos(ang);
    return longint'($rtoi($floor(v * $itor(1 << (TW - 2)) + 0.5)));
  endfunction

  // Expected output p of the span whose index 0 was accepted at edge start (R2, R3).
  function automatic logic [2*OW-1:0] expect_out(int start, int p);
    int k;
    logic [2*DW-1:0] a, b;
    longint ar, ai, br, bi, r, i, dr, di, wr, wi;
    logic [63:0] rv, iv;
    k  = p % H;
    a  = hist[(start + k) % HIST];
    b  = hist[(start + k + H) % HIST];
    ar = longint'($signed(a[2*DW-1:DW]));
    ai = longint'($signed(a[DW-1:0]));
    br = longint'($signed(b[2*DW-1:DW]));
    bi = longint'($signed(b[DW-1:0]));
    if (p < H) begin
      r = ar + br;
      i = ai + bi;
    end else begin
      dr = ar - br; di = ai - bi;
      wr = twid(k, 1'b0); wi = twid(k, 1'b1);
      r = (dr * wr - di * wi) >>> (TW - 2);
      i = (dr * wi + di * wr) >>> (TW - 2);
    end
    rv = r; iv = i;
    return {rv[OW-1:0], iv[OW-1:0]};
  endfunction

  // Look at what the last posedge produced.
  task automatic observe();
    bit exp_s;
    if (prev_ce) begin
      ecount++;
      exp_s = (q_edge.size() > 0) && (q_edge[0] == ecount);
      check(out_sync == exp_s, "R4 sync position", longint'(out_sync), longint'(exp_s));
      if (exp_s) begin
        void'(q_edge.pop_front());
        cur_start = q_start.pop_front();
        cur_tag   = q_tag.pop_front();
        act = 1; pos = 0;
      end
      if (act) begin
        check(out_sample == expect_out(cur_start, pos),
              (pos < H) ? {"R2 sum", cur_tag} : {"R3 rotated difference", cur_tag},
              longint'(out_sample), longint'(expect_out(cur_start, pos)));
        pos++;
        if (pos == N) act = 0;
      end
    end else if (!rst) begin
      check(out_sample == last_out && out_sync == last_sync, "R5 hold while idle",
            longint'(out_sample), longint'(last_out));
    end
    last_out  = out_sample;
    last_sync = out_sync;
  endtask

  task automatic cycle(bit c, bit s, logic [2*DW-1:0] d);
    int e, idx;
    @(negedge clk);
    observe();
    ce = c; in_sync = s; in_sample = d;
    if (c) begin
      e = ecount + 1;
      hist[e % HIST] = d;
      if (s || m_run) begin
        idx = s ? 0 : m_cnt;
        if (idx == 0) begin
          span_tag_restart = s && m_run && (m_cnt != 0);
          span_tag_nosync  = !s;
        end
        if (idx == H) begin
          q_edge.push_back(e + LAT + 1);
          q_start.push_back(e - H);
          q_tag.push_back(span_tag_restart ? " R7 after restart" :
                          (span_tag_nosync ? " R6 wrapped span" : ""));
        end
        m_cnt = (idx + 1) % N;
        m_run = 1;
      end
    end
    prev_ce = c;
  endtask

  function automatic logic [2*DW-1:0] pack(int re, int im);
    logic [DW-1:0] a, b;
    a = DW'(re); b = DW'(im);
    return {a, b};
  endfunction

  function automatic logic [2*DW-1:0] gen(int kind, int i);
    int mx, mn;
    mx = (1 << (DW - 1)) - 1;
    mn = -(1 << (DW - 1));
    case (kind)
      1: return pack(i * 37 - 100, 50 - i * 23);
      2: return (i < H) ? pack(mx, mn) : pack(mn, mx);
      3: return '0;
      default: return $urandom();
    endcase
  endfunction

  task automatic send_span(int kind, bit give_sync, int ce_pct, int count);
    for (int i = 0; i < count; i++) begin
      while (($urandom() % 100) >= ce_pct) cycle(1'b0, 1'b0, $urandom());
      cycle(1'b1, give_sync && (i == 0), gen(kind, i));
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    // R1: cleared outputs after reset, nothing enabled yet
    check(out_sync == 1'b0, "R1 reset sync", longint'(out_sync), 0);
    check(out_sample == '0, "R1 reset sample", longint'(out_sample), 0);
    last_out = out_sample; last_sync = out_sync;

    // R7: samples before any in_sync are dropped (no sync may follow)
    send_span(0, 1'b0, 100, 5);
    repeat (12) cycle(1'b0, 1'b0, '0);

    // Directed spans at full rate; only the first carries in_sync (R6)
    send_span(1, 1'b1, 100, N);
    send_span(2, 1'b0, 100, N);
    send_span(3, 1'b0, 100, N);
    send_span(2, 1'b0, 100, N);

    // Random data with random ce gaps (R5), in_sync sometimes repeated
    for (int s = 0; s < 30; s++) send_span(0, ($urandom() % 2) == 1, 70, N);

    // R7: restart in the first half of a span
    send_span(0, 1'b0, 80, 2);
    send_span(2, 1'b1, 80, N);
    for (int s = 0; s < 6; s++) send_span(0, 1'b0, 60, N);

    // Drain: keep feeding so pending outputs appear
    for (int s = 0; s < 3; s++) send_span(3, 1'b0, 100, N);
    cycle(1'b0, 1'b0, '0);
    cycle(1'b0, 1'b0, '0);

    check(q_edge.size() <= 3, "R4 pending syncs drained", longint'(q_edge.size()), 3);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL R6 watchdog: got running expected finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule